// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small, fully associative store of recent page translations. It sits between a core's load/store or fetch path and the memory system. Each request carries a 32-bit virtual address, an address-space identifier and an access kind. In the same cycle the block answers with one of three outcomes:

- a hit, together with the physical address;
- a miss, which tells the requester to consult the page table;
- a permission fault, when a matching translation forbids that kind of access.

Pages are 4 KB. The low twelve address bits pass through untouched, and the upper twenty bits are replaced by the stored physical page number.

Translations are installed through a separate fill port, driven by a table walker or by software after a miss. A fill whose page and identifier are already present overwrites that slot. Otherwise the fill takes the lowest free slot, or, when every slot is valid, the slot named by a round-robin pointer. Each slot is tagged with an address-space identifier, so a context switch needs no flush. Two flush controls are provided: one clears everything, the other clears only the slots of a single identifier.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss with `lk_hit` and `lk_fault` low and `lk_paddr` zero.
- R2: A lookup hits in the same cycle when a valid slot matches both the page number (`lk_vaddr[31:12]`) and `lk_asid`, and the access is permitted. It then returns `lk_paddr = {stored page, lk_vaddr[11:0]}`.
- R3: The permission field is bit 0 read, bit 1 write, bit 2 execute. `lk_acc` is coded 0 read, 1 write, 2 execute; code 3 is never permitted. A matching slot that does not permit the access raises `lk_fault` with `lk_hit` and `lk_miss` low and `lk_paddr` zero.
- R4: A lookup for which no valid slot matches both page and identifier reports `lk_miss` with `lk_paddr` zero.
- R5: When `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. When `lk_valid` is low, all three are low and `lk_paddr` is zero.
- R6: A fill that matches no valid slot, while some slot is empty, is written into the lowest-index empty slot and leaves the replacement pointer unchanged.
- R7: A fill that matches no slot, while all slots are valid, replaces the slot at the replacement pointer and advances the pointer by one, modulo the slot count. The pointer is 0 after reset and is not changed by flushes.
- R8: A fill whose page and identifier match a valid slot rewrites that slot's page and permissions in place. No other slot changes and the pointer does not move.
- R9: `flush_all` invalidates every slot at the next clock edge.
- R10: `flush_asid_en` invalidates, at the next clock edge, exactly the slots whose identifier equals `flush_asid`; all other slots keep their translations.
- R11: A fill takes effect at the next clock edge, so a lookup in the same cycle sees the old contents. A fill presented in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | ASID_W | Identifier of the requesting address space |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No matching translation |
| lk_fault | output | 1 | Matching translation forbids the access |
| lk_paddr | output | 32 | Physical address (zero unless hit) |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_asid | input | ASID_W | Identifier of the installed translation |
| fill_ppn | input | 20 | Physical page number to install |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate slots of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
After every change of contents, the lookup path is swept over a fixed set of twelve page numbers, crossed with every identifier and every access code, including the reserved one. Pages that are present only under another identifier separate identifier tagging from page matching. The eight permission combinations, spread over the slots, separate each permission bit from its neighbours.

The fill sequences are built to tell apart the three placement rules. Filling beyond capacity shows the pointer order. A rewrite in place followed by another overflow shows that a rewrite does not move the pointer. A selective flush followed by fills shows that empty slots are taken before any eviction. Fills presented alongside a flush, and lookups made in the same cycle as a fill, pin the timing of updates.

// File: rtl/tlb_pkg.sv
// Package: shared widths and the access-kind encoding for the translation buffer.
// Assumes 32-bit virtual and physical addresses with 4 KB pages.
package tlb_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int PN_W   = ADDR_W - OFF_W;
    localparam int PERM_W = 3;

    // Access kinds; the value doubles as the index of the permission bit.
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/tlb_slot.sv
// Module: one translation slot. It holds a valid bit, page tags, the identifier
// and the permissions, and it compares against the lookup and fill keys.
// Assumes the caller asserts wr only when no flush is active in that cycle.
module tlb_slot #(
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              flush_sel,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              wr,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              valid_o,
    output logic              lk_match,
    output logic              fill_match,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [PERM_W-1:0] perm_o
);
    logic              valid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PERM_W-1:0] perm_q;

    // Valid bit: reset, flush-all, flush by identifier, then set on write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 valid_q <= 1'b0;
        else if (flush_all)                         valid_q <= 1'b0;
        else if (flush_sel && asid_q == flush_asid) valid_q <= 1'b0;
        else if (wr)                                valid_q <= 1'b1;
    end

    // Payload: captured on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            asid_q <= '0;
            ppn_q  <= '0;
            perm_q <= '0;
        end else if (wr) begin
            vpn_q  <= wr_vpn;
            asid_q <= wr_asid;
            ppn_q  <= wr_ppn;
            perm_q <= wr_perm;
        end
    end

    // Key compare for the lookup path and for duplicate detection on fill.
    always_comb begin
        lk_match   = valid_q && vpn_q == lk_vpn && asid_q == lk_asid;
        fill_match = valid_q && vpn_q == wr_vpn && asid_q == wr_asid;
    end

    assign valid_o = valid_q;
    assign ppn_o   = ppn_q;
    assign perm_o  = perm_q;

    // R9: after a flush-all the slot is empty.
    assert_slot_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !valid_o);
endmodule

// File: rtl/tlb_victim.sv
// Module: chooses the slot to write on a fill. An existing duplicate comes
// first, then the lowest empty slot, then the round-robin pointer.
// Assumes dup_vec has at most one bit set.
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    input  logic               install,
    output logic [ENTRIES-1:0] sel
);
    logic [IDX_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] empty_vec;
    logic [ENTRIES-1:0] lowest_empty;
    logic               any_dup;
    logic               all_full;
    logic               evict;

    // Select the target slot for this cycle's fill.
    always_comb begin
        empty_vec    = ~valid_vec;
        lowest_empty = empty_vec & (~empty_vec + 1'b1);
        any_dup      = |dup_vec;
        all_full     = &valid_vec;
        evict        = install && !any_dup && all_full;
        if (any_dup)        sel = dup_vec;
        else if (!all_full) sel = lowest_empty;
        else begin
            sel = '0;
            sel[ptr_q] = 1'b1;
        end
    end

    // Round-robin pointer: advances only when a valid slot is evicted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (evict)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R6, R8: the pointer holds unless a full buffer evicts a slot.
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !evict |=> $stable(ptr_q));
    // R7: the pointer always names an existing slot.
    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= IDX_W'(ENTRIES - 1));
    // R8: exactly one target slot is chosen.
    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel));
endmodule

// File: rtl/tlb_fa.sv
// Module: top of the fully associative translation buffer. Lookups are
// combinational; fills and flushes take effect at the next clock edge.
// Assumes at most one slot matches a key (kept true by in-place rewrite).
module tlb_fa #(
    parameter int ENTRIES = 32,
    parameter int ASID_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [tlb_pkg::ADDR_W-1:0] lk_vaddr,
    input  logic [ASID_W-1:0]          lk_asid,
    input  logic [1:0]                 lk_acc,
    output logic                       lk_hit,
    output logic                       lk_miss,
    output logic                       lk_fault,
    output logic [tlb_pkg::ADDR_W-1:0] lk_paddr,
    input  logic                       fill_en,
    input  logic [tlb_pkg::PN_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]          fill_asid,
    input  logic [tlb_pkg::PN_W-1:0]   fill_ppn,
    input  logic [tlb_pkg::PERM_W-1:0] fill_perm,
    input  logic                       flush_all,
    input  logic                       flush_asid_en,
    input  logic [ASID_W-1:0]          flush_asid
);
    import tlb_pkg::*;

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] dup_vec;
    logic [ENTRIES-1:0] sel_vec;
    logic [PN_W-1:0]    ppn_arr  [ENTRIES];
    logic [PERM_W-1:0]  perm_arr [ENTRIES];
    logic               install;
    logic               any_match;
    logic [PN_W-1:0]    hit_ppn;
    logic [PERM_W-1:0]  hit_perm;
    logic               permitted;

    // A fill is dropped whenever any flush is requested in the same cycle.
    assign install = fill_en && !flush_all && !flush_asid_en;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tlb_slot #(
            .VPN_W (PN_W),
            .PPN_W (PN_W),
            .ASID_W(ASID_W),
            .PERM_W(PERM_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_all (flush_all),
            .flush_sel (flush_asid_en),
            .flush_asid(flush_asid),
            .wr        (install && sel_vec[i]),
            .wr_vpn    (fill_vpn),
            .wr_asid   (fill_asid),
            .wr_ppn    (fill_ppn),
            .wr_perm   (fill_perm),
            .lk_vpn    (lk_vaddr[ADDR_W-1:OFF_W]),
            .lk_asid   (lk_asid),
            .valid_o   (valid_vec[i]),
            .lk_match  (match_vec[i]),
            .fill_match(dup_vec[i]),
            .ppn_o     (ppn_arr[i]),
            .perm_o    (perm_arr[i])
        );
    end

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_vec(valid_vec),
        .dup_vec  (dup_vec),
        .install  (install),
        .sel      (sel_vec)
    );

    // OR-merge the payload of the single matching slot.
    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ppn  = hit_ppn  | (match_vec[i] ? ppn_arr[i]  : '0);
            hit_perm = hit_perm | (match_vec[i] ? perm_arr[i] : '0);
        end
        any_match = |match_vec;
    end

    // Permission check: the access code indexes the permission field.
    always_comb begin
        unique case (acc_kind_t'(lk_acc))
            ACC_READ:  permitted = hit_perm[0];
            ACC_WRITE: permitted = hit_perm[1];
            ACC_EXEC:  permitted = hit_perm[2];
            default:   permitted = 1'b0;
        endcase
    end

    // Outcome and address formation.
    always_comb begin
        lk_hit   = lk_valid && any_match && permitted;
        lk_fault = lk_valid && any_match && !permitted;
        lk_miss  = lk_valid && !any_match;
        lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[OFF_W-1:0]} : '0;
    end

    // R2: the page offset passes through unchanged on a hit.
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);
    // R5: exactly one outcome per request, none without a request.
    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lk_hit, lk_miss, lk_fault}) == (lk_valid ? 1 : 0));
    // R8: no two slots ever hold the same key.
    assert_unique_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    // R9: a flush-all leaves the buffer empty.
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> valid_vec == '0);
    // R11: an accepted fill leaves a valid slot holding its key.
    assert_fill_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> |valid_vec);
endmodule

// File: tb/tlb_fa_bench.sv
// Bench: eight-slot configuration, reference model built from the requirements.
module tlb_fa_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int AW         = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [AW-1:0] lk_asid;
    logic [1:0]  lk_acc;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic        fill_en;
    logic [19:0] fill_vpn, fill_ppn;
    logic [AW-1:0] fill_asid;
    logic [2:0]  fill_perm;
    logic        flush_all, flush_asid_en;
    logic [AW-1:0] flush_asid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state.
    bit          m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    logic [AW-1:0] m_asid [N];
    logic [2:0]  m_perm  [N];
    int          m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa #(.ENTRIES(N), .ASID_W(AW)) u_tlb_fa (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    function automatic logic [19:0] vpn_of(input int v);
        return 20'h00010 + 20'(v) * 20'h01235;
    endfunction

    function automatic logic [19:0] ppn_of(input int v, input int gen);
        return 20'hA0000 ^ (20'(v) * 20'h00713) ^ (20'(gen) << 12);
    endfunction

    // One lookup compared with the model; ctx names the requirement under test.
    task automatic look(input logic [31:0] va, input logic [AW-1:0] as,
                        input logic [1:0] acc, input string ctx);
        logic ehit, emiss, efault;
        logic [31:0] epa;
        string req;
        int idx;
        idx = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == va[31:12] && m_asid[i] == as) idx = i;
        emiss  = (idx < 0);
        ehit   = !emiss && acc != 2'd3 && m_perm[idx][acc];
        efault = !emiss && !ehit;
        epa    = ehit ? {m_ppn[idx], va[11:0]} : 32'h0;
        req    = emiss ? "R4" : (efault ? "R3" : "R2");
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = as; lk_acc = acc;
        #1;
        checks++;
        if ({lk_hit, lk_miss, lk_fault} !== {ehit, emiss, efault} || lk_paddr !== epa) begin
            errors++;
            $display("FAIL %s/%s va=%h asid=%0d acc=%0d: got h/m/f=%b%b%b pa=%h, expected %b%b%b pa=%h",
                     ctx, req, va, as, acc, lk_hit, lk_miss, lk_fault, lk_paddr,
                     ehit, emiss, efault, epa);
        end
        lk_valid = 1'b0;
    endtask

    // Sweep twelve pages x every identifier x every access code.
    task automatic sweep(input string ctx);
        for (int v = 0; v < 12; v++)
            for (int a = 0; a < 4; a++)
                for (int c = 0; c < 4; c++)
                    look({vpn_of(v), 12'(v * 37 + a * 5 + c)}, AW'(a), 2'(c), ctx);
    endtask

    // Fill through the port; a lookup of the same key in that cycle must see old state (R11).
    task automatic fill(input int v, input int as, input int gen, input logic [2:0] perm);
        int tgt;
        look({vpn_of(v), 12'h0AB}, AW'(as), 2'd0, "R11");
        fill_en = 1'b1; fill_vpn = vpn_of(v); fill_asid = AW'(as);
        fill_ppn = ppn_of(v, gen); fill_perm = perm;
        @(negedge clk);
        fill_en = 1'b0;
        if (!flush_all && !flush_asid_en) begin
            tgt = -1;
            for (int i = 0; i < N; i++)
                if (m_valid[i] && m_vpn[i] == vpn_of(v) && m_asid[i] == AW'(as)) tgt = i;
            if (tgt < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) tgt = i;
            if (tgt < 0) begin
                tgt = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_valid[tgt] = 1'b1; m_vpn[tgt] = vpn_of(v); m_asid[tgt] = AW'(as);
            m_ppn[tgt] = ppn_of(v, gen); m_perm[tgt] = perm;
        end
    endtask

    task automatic model_flush(input bit all, input logic [AW-1:0] as);
        for (int i = 0; i < N; i++)
            if (all || m_asid[i] == as) m_valid[i] = 1'b0;
    endtask

    task automatic do_flush_all();
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        model_flush(1'b1, '0);
    endtask

    task automatic do_flush_asid(input int as);
        flush_asid_en = 1'b1; flush_asid = AW'(as);
        @(negedge clk);
        flush_asid_en = 1'b0;
        model_flush(1'b0, AW'(as));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_asid = '0; lk_acc = '0;
        fill_en = 1'b0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0; fill_perm = '0;
        flush_all = 1'b0; flush_asid_en = 1'b0; flush_asid = '0;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0; m_perm[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: no request, no outcome.
        #1;
        checks++;
        if ({lk_hit, lk_miss, lk_fault} !== 3'b000 || lk_paddr !== 32'h0) begin
            errors++;
            $display("FAIL R5 idle: got h/m/f=%b%b%b pa=%h, expected 000 pa=00000000",
                     lk_hit, lk_miss, lk_fault, lk_paddr);
        end
        @(negedge clk);

        sweep("R1");                                      // empty after reset
        for (int v = 0; v < N; v++) fill(v, v % 4, 0, 3'(v)); // R6: fills empties in order
        sweep("R6");
        fill(8, 1, 0, 3'b111);                            // R7: evicts slot 0
        sweep("R7");
        fill(9, 2, 0, 3'b101);                            // R7: evicts slot 1
        sweep("R7");
        fill(3, 3, 1, 3'b111);                            // R8: rewrite in place
        sweep("R8");
        fill(10, 0, 0, 3'b011);                           // R8: pointer unmoved, evicts slot 2
        sweep("R8");
        do_flush_asid(1);                                 // R10: selective flush
        sweep("R10");
        fill(11, 0, 0, 3'b110);                           // R6: lowest empty slot
        fill(4, 1, 2, 3'b001);                            // R6
        sweep("R6");

        // R11: fills alongside either flush are dropped.
        flush_asid_en = 1'b1; flush_asid = AW'(2);
        fill(5, 3, 3, 3'b111);
        flush_asid_en = 1'b0;
        model_flush(1'b0, AW'(2));
        sweep("R11");
        flush_all = 1'b1;
        fill(6, 2, 3, 3'b111);
        flush_all = 1'b0;
        model_flush(1'b1, '0);
        sweep("R11");

        // R7: pointer survives flushes; refill then overflow again.
        for (int v = 0; v < N; v++) fill(v, (v + 1) % 4, 4, 3'(7 - v));
        fill(9, 0, 4, 3'b100);
        fill(10, 3, 4, 3'b010);
        sweep("R7");
        do_flush_all();                                   // R9
        sweep("R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule